// File: doc/BRIEF.md
# Compare-Match Waveform Timer

An up-counting timer with a parameterised width (16 bits by default) that advances once for each pulse on a prescaler tick input. The counter restarts from zero after it reaches a top value. The top value comes from one of two registers: the primary compare register or the capture register. The block has two families of operation. In clear-on-match operation, writes to the compare register take effect at once. In single-slope PWM operation, the counter ramps from zero to top and starts again, and the compare register is double-buffered so that it changes only at a period boundary.

A waveform output is driven from the compare events. It can toggle, clear or set on a match. In PWM operation it can form a non-inverting or an inverting pulse. Three sticky status flags record a primary compare match, a capture-register match and an all-ones rollover. Software clears a flag by writing a one to its bit. The prescaler itself lives outside the block: a divider that pulses `tick` once every N clock cycles, with N chosen from 1, 8, 64, 256 or 1024, sets the time base.

Top module: `match_wave_timer`

## Requirements
- R1: After reset the count, both registers, the waveform and all three flags are zero.
- R2: The count changes only in a cycle with `tick` high. It then moves up by one, or it goes to zero when the count before the tick equals the selected top. With `tick` low the count holds.
- R3: `modeSel` selects the operation: 0 = clear-on-match with compare A as top, 1 = clear-on-match with capture as top, 2 = PWM with capture as top, 3 = PWM with compare A as top. A tick at top clears the count.
- R4: Register writes use `wrSel` 0 for compare A, 1 for capture and 2 for flag clear. In modes 0 and 1 a compare A write takes effect in the next cycle. If the written top is below the current count, the count runs on to all ones, wraps to zero and matches only after that.
- R5: Flag bit 2 (overflow) is set by a tick at which the count is all ones.
- R6: Flag bit 0 is set by a tick at which the count equals the active compare A, in any mode. Flag bit 1 is set by a tick at which the count equals the capture register while the capture register is top. The flags stay set until a `wrSel` 2 write with a one in that bit position. A set in the same cycle as a clear wins.
- R7: With `outSel` 1, the waveform inverts on every compare A match. Its period is therefore 2·N·(1+TOP) clock cycles, which is one clock per level when N is 1 and TOP is 0.
- R8: In modes 2 and 3, a compare A write lands in a buffer. The buffer is copied into the active compare register on the tick at which the count is at top. A top written below the current count therefore takes effect only after the period in progress has ended.
- R9: In PWM modes, `outSel` 2 sets the waveform on the tick at top and clears it on a compare A match. `outSel` 3 does the opposite. Top takes priority, so a compare value equal to top gives a constant level.
- R10: In modes 0 and 1, `outSel` 2 clears the waveform on a compare A match and `outSel` 3 sets it. With `outSel` 0, `waveOut` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler clock enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target: 0 compare A, 1 capture, 2 flag clear |
| wrData | input | WIDTH | Write data (bits 2:0 form the clear mask for flag clear) |
| modeSel | input | 2 | Operating mode |
| outSel | input | 2 | Waveform output behaviour |
| countOut | output | WIDTH | Current count |
| waveOut | output | 1 | Waveform output |
| flags | output | 3 | Sticky flags: bit 0 compare A, bit 1 capture, bit 2 overflow |

## Verification
The bench builds the timer with WIDTH set to 8. At that width the all-ones rollover, the missed-compare wrap and the overflow flag are reached in a few hundred ticks, where a 16-bit counter would need tens of thousands. The bench drives the tick input with a divide of 1 for most tests. It uses divides of 1 and 8 to check the toggle period, so the maximum-frequency corner and a prescaled period are both measured in clock cycles.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

  typedef enum logic [1:0] {
    MODE_CLR_A   = 2'd0,
    MODE_CLR_CAP = 2'd1,
    MODE_PWM_CAP = 2'd2,
    MODE_PWM_A   = 2'd3
  } timerMode_e;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_TOGGLE = 2'd1,
    OUT_LOWISH = 2'd2,
    OUT_HIGHISH = 2'd3
  } outMode_e;

  localparam logic [1:0] SEL_CMPA    = 2'd0;
  localparam logic [1:0] SEL_CAP     = 2'd1;
  localparam logic [1:0] SEL_FLAGCLR = 2'd2;

  localparam int FLAG_BITS = 3;

  typedef struct packed {
    logic                 advance;
    logic                 clearCount;
    logic                 loadA;
    logic                 matchA;
    logic                 matchCap;
    logic                 atTop;
    logic                 wrap;
    logic                 isPwm;
    logic [FLAG_BITS-1:0] clrMask;
  } strobe_t;

endpackage

// File: rtl/mwt_datapath.sv
module mwt_datapath
  import mwt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] activeA,
  output logic [WIDTH-1:0] capReg
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] bufA;
  logic             wrA;
  logic             wrCap;

  assign wrA   = wrEn && (wrSel == SEL_CMPA);
  assign wrCap = wrEn && (wrSel == SEL_CAP);

  logic unusedStrb;
  assign unusedStrb = ^{strb.matchA, strb.matchCap, strb.atTop, strb.wrap, strb.clrMask};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= ZERO;
    end else if (strb.clearCount) begin
      count <= ZERO;
    end else if (strb.advance) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufA    <= ZERO;
      activeA <= ZERO;
      capReg  <= ZERO;
    end else begin
      if (wrA) bufA <= wrData;
      if (wrA && !strb.isPwm) begin
        activeA <= wrData;
      end else if (strb.loadA) begin
        activeA <= bufA;
      end
      if (wrCap) capReg <= wrData;
    end
  end

  a_r2_hold_without_tick : assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(count));

  a_r2_step_on_tick : assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.clearCount) |=> (count == WIDTH'($past(count) + 1'b1)));

  a_r3_clear_at_top : assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCount |=> (count == ZERO));

  a_r8_buffered_hold : assert property (@(posedge clk) disable iff (!rstN)
    (strb.isPwm && !strb.loadA) |=> $stable(activeA));

endmodule

// File: rtl/mwt_control.sv
module mwt_control
  import mwt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                 tick,
  input  timerMode_e           mode,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [FLAG_BITS-1:0] wrMask,
  input  logic [WIDTH-1:0]     count,
  input  logic [WIDTH-1:0]     activeA,
  input  logic [WIDTH-1:0]     capReg,
  output strobe_t              strb
);

  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  logic             useCap;
  logic             pwmMode;
  logic [WIDTH-1:0] topVal;
  logic             hitTop;

  always_comb begin
    useCap  = (mode == MODE_CLR_CAP) || (mode == MODE_PWM_CAP);
    pwmMode = (mode == MODE_PWM_CAP) || (mode == MODE_PWM_A);
    topVal  = useCap ? capReg : activeA;
    hitTop  = (count == topVal);
  end

  always_comb begin
    strb            = '0;
    strb.advance    = tick;
    strb.isPwm      = pwmMode;
    strb.atTop      = tick && hitTop;
    strb.clearCount = tick && hitTop;
    strb.loadA      = tick && hitTop && pwmMode;
    strb.matchA     = tick && (count == activeA);
    strb.matchCap   = tick && useCap && (count == capReg);
    strb.wrap       = tick && (count == ALL_ONES);
    strb.clrMask    = (wrEn && (wrSel == SEL_FLAGCLR)) ? wrMask : '0;
  end

endmodule

// File: rtl/mwt_outgen.sv
module mwt_outgen
  import mwt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  outMode_e             outMode,
  output logic                 waveOut,
  output logic [FLAG_BITS-1:0] flags
);

  logic                 waveReg;
  logic                 waveNext;
  logic [FLAG_BITS-1:0] setMask;

  logic unusedStrb;
  assign unusedStrb = ^{strb.advance, strb.clearCount, strb.loadA};

  assign setMask = {strb.wrap, strb.matchCap, strb.matchA};

  always_comb begin
    waveNext = waveReg;
    unique case (outMode)
      OUT_OFF:    waveNext = waveReg;
      OUT_TOGGLE: if (strb.matchA) waveNext = ~waveReg;
      OUT_LOWISH: begin
        if (strb.isPwm && strb.atTop) waveNext = 1'b1;
        else if (strb.matchA)         waveNext = 1'b0;
      end
      OUT_HIGHISH: begin
        if (strb.isPwm && strb.atTop) waveNext = 1'b0;
        else if (strb.matchA)         waveNext = 1'b1;
      end
      default: waveNext = waveReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waveReg <= 1'b0;
      flags   <= '0;
    end else begin
      waveReg <= waveNext;
      flags   <= (flags & ~strb.clrMask) | setMask;
    end
  end

  assign waveOut = (outMode == OUT_OFF) ? 1'b0 : waveReg;

  a_r5_overflow_sets : assert property (@(posedge clk) disable iff (!rstN)
    strb.wrap |=> flags[2]);

  a_r6_set_wins : assert property (@(posedge clk) disable iff (!rstN)
    strb.matchA |=> flags[0]);

  a_r6_sticky : assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !strb.clrMask[0]) |=> flags[0]);

  a_r7_toggle : assert property (@(posedge clk) disable iff (!rstN)
    (outMode == OUT_TOGGLE && strb.matchA) |=> (waveReg != $past(waveReg)));

  a_r10_off_low : assert property (@(posedge clk) disable iff (!rstN)
    (outMode == OUT_OFF) |-> !waveOut);

endmodule

// File: rtl/match_wave_timer.sv
module match_wave_timer
  import mwt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       modeSel,
  input  logic [1:0]       outSel,
  output logic [WIDTH-1:0] countOut,
  output logic             waveOut,
  output logic [2:0]       flags
);

  strobe_t          strb;
  logic [WIDTH-1:0] activeA;
  logic [WIDTH-1:0] capReg;
  timerMode_e       modeE;
  outMode_e         outE;

  assign modeE = timerMode_e'(modeSel);
  assign outE  = outMode_e'(outSel);

  mwt_control #(.WIDTH(WIDTH)) uCtrl (
    .tick    (tick),
    .mode    (modeE),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrMask  (wrData[FLAG_BITS-1:0]),
    .count   (countOut),
    .activeA (activeA),
    .capReg  (capReg),
    .strb    (strb)
  );

  mwt_datapath #(.WIDTH(WIDTH)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .wrData  (wrData),
    .count   (countOut),
    .activeA (activeA),
    .capReg  (capReg)
  );

  mwt_outgen uOut (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .outMode (outE),
    .waveOut (waveOut),
    .flags   (flags)
  );

endmodule

// File: tb/match_wave_timer_test.sv
`timescale 1ns/1ps
module match_wave_timer_test;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         tick = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrSel = 2'd0;
  logic [W-1:0] wrData = '0;
  logic [1:0]   modeSel = 2'd0;
  logic [1:0]   outSel = 2'd0;
  logic [W-1:0] countOut;
  logic         waveOut;
  logic [2:0]   flags;

  int nChecks = 0;
  int nFails  = 0;

  match_wave_timer #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .modeSel(modeSel), .outSel(outSel),
    .countOut(countOut), .waveOut(waveOut), .flags(flags)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  outm;
    logic [7:0]  a;
    logic [7:0]  cap;
    logic [15:0] n;
    logic [7:0]  expCount;
    logic        expWave;
    logic [2:0]  expFlags;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd1, 8'd4,   8'd0, 16'd7,   8'd2, 1'b1, 3'b001},
    '{2'd1, 2'd1, 8'd2,   8'd5, 16'd7,   8'd1, 1'b1, 3'b011},
    '{2'd2, 2'd2, 8'd2,   8'd7, 16'd9,   8'd1, 1'b1, 3'b011},
    '{2'd2, 2'd2, 8'd2,   8'd7, 16'd11,  8'd3, 1'b0, 3'b011},
    '{2'd2, 2'd3, 8'd2,   8'd7, 16'd11,  8'd3, 1'b1, 3'b011},
    '{2'd0, 2'd0, 8'd0,   8'd0, 16'd5,   8'd0, 1'b0, 3'b001},
    '{2'd0, 2'd1, 8'd0,   8'd0, 16'd5,   8'd0, 1'b1, 3'b001},
    '{2'd0, 2'd1, 8'd255, 8'd0, 16'd256, 8'd0, 1'b1, 3'b101},
    '{2'd3, 2'd2, 8'd5,   8'd0, 16'd6,   8'd0, 1'b1, 3'b001}
  };

  task automatic check(input string tag, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tick = 1'b0; wrEn = 1'b0; modeSel = 2'd0; outSel = 2'd0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [W-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1'b1;
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic setup(input logic [1:0] m, input logic [1:0] o,
                       input logic [W-1:0] a, input logic [W-1:0] c);
    doReset();
    writeReg(2'd0, a);
    writeReg(2'd1, c);
    modeSel = m;
    outSel  = o;
  endtask

  task automatic measure(input int divN, input logic [W-1:0] top, output int spacing);
    int t [3];
    int nChg;
    logic prev;
    setup(2'd0, 2'd1, top, 8'd0);
    nChg = 0;
    prev = waveOut;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (waveOut != prev && nChg < 3) begin
        t[nChg] = i;
        nChg++;
      end
      prev = waveOut;
      tick = ((i % divN) == 0);
    end
    tick = 1'b0;
    spacing = (nChg == 3) ? (t[2] - t[1]) : -1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int sp;

    // R1 reset state
    doReset();
    check("R1 count", countOut, 0);
    check("R1 wave", waveOut, 0);
    check("R1 flags", flags, 0);

    // Vector table: R3 R5 R6 R7 R9 R10 under several modes
    for (int v = 0; v < NVEC; v++) begin
      setup(VECS[v].mode, VECS[v].outm, VECS[v].a, VECS[v].cap);
      runTicks(int'(VECS[v].n));
      check($sformatf("R3 vec%0d count", v), countOut, VECS[v].expCount);
      check($sformatf("R9 vec%0d wave", v), waveOut, VECS[v].expWave);
      check($sformatf("R6 vec%0d flags", v), flags, VECS[v].expFlags);
    end

    // R2 count holds while tick is low
    setup(2'd0, 2'd0, 8'd10, 8'd0);
    runTicks(3);
    repeat (5) @(negedge clk);
    check("R2 hold", countOut, 3);

    // R4 immediate top write in clear-on-match mode
    setup(2'd0, 2'd0, 8'd200, 8'd0);
    runTicks(10);
    writeReg(2'd0, 8'd12);
    runTicks(2);
    check("R4 immediate reach", countOut, 12);
    runTicks(1);
    check("R4 immediate clear", countOut, 0);

    // R4 R5 missed compare wraps through all ones
    setup(2'd0, 2'd0, 8'd200, 8'd0);
    runTicks(100);
    writeReg(2'd0, 8'd50);
    runTicks(155);
    check("R4 runs past", countOut, 255);
    check("R4 no flags yet", flags, 0);
    runTicks(1);
    check("R4 wrap", countOut, 0);
    check("R5 overflow flag", flags, 3'b100);
    runTicks(50);
    check("R4 reach late", countOut, 50);
    runTicks(1);
    check("R4 late clear", countOut, 0);
    check("R6 late match flag", flags, 3'b101);

    // R8 double-buffered top in PWM
    setup(2'd3, 2'd0, 8'd9, 8'd0);
    runTicks(4);
    writeReg(2'd0, 8'd2);
    runTicks(5);
    check("R8 old top kept", countOut, 9);
    runTicks(1);
    check("R8 period ends", countOut, 0);
    check("R8 no overflow", flags[2], 0);
    runTicks(2);
    check("R8 new top reached", countOut, 2);
    runTicks(1);
    check("R8 new top clears", countOut, 0);

    // R6 set wins over same-cycle clear, and clear is per bit
    setup(2'd1, 2'd0, 8'd3, 8'd3);
    runTicks(3);
    @(negedge clk);
    tick = 1'b1; wrEn = 1'b1; wrSel = 2'd2; wrData = 8'd3;
    @(negedge clk);
    tick = 1'b0; wrEn = 1'b0;
    check("R6 set wins", flags, 3'b011);
    writeReg(2'd2, 8'd1);
    check("R6 clear bit0 only", flags, 3'b010);
    writeReg(2'd2, 8'd2);
    check("R6 clear bit1", flags, 0);

    // R10 clear-on-match set and clear behaviour
    setup(2'd0, 2'd3, 8'd2, 8'd0);
    runTicks(3);
    check("R10 set on match", waveOut, 1);
    outSel = 2'd2;
    runTicks(3);
    check("R10 clear on match", waveOut, 0);

    // R7 toggle period in clock cycles
    measure(1, 8'd0, sp);
    check("R7 half period N1 top0", sp, 1);
    measure(8, 8'd3, sp);
    check("R7 half period N8 top3", sp, 32);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule